// File: doc/BRIEF.md
# Physical Address Region Type Classifier

This block keeps a small table of physical address windows. Each window has a byte base, a byte length and a region type code. For an incoming address it returns the region type that applies and whether the address may be handed to a physical page allocator. Every table slot compares the address against its own window at the same time. A reduction stage then picks the most restrictive type among the slots that cover the address. Addresses that no slot covers are classified as reserved, and so are slots whose type code is not recognised.

Software or a boot engine fills the table through a single write port. Each write carries a slot index, a base, a length, a type code and a valid bit. Lookups are presented as a request with an address. The answer appears on the response outputs one clock later, from a register. Reclaimable regions count as allocatable only while the reclaim-done input is high. That input shows that the tables stored in those regions have been consumed.

Top module: `addr_region_classifier`

## Requirements
- R1: After reset every slot is invalid, `rsp_valid` is 0, and any lookup returns type 2 with `rsp_alloc` = 0 until a slot is written.
- R2: `rsp_type` is a 3-bit code: 1 usable RAM, 2 reserved, 3 reclaimable, 4 firmware non-volatile, 5 defective. No other value appears while `rsp_valid` is 1.
- R3: An address covered by no valid slot returns type 2.
- R4: A slot written with an 8-bit type code other than 1 to 5 (for example 0 or 9) behaves as a type 2 slot.
- R5: When several valid slots cover the address, the result is the most restrictive of their types. The ranking from least to most restrictive is 1, 3, 4, 2, 5.
- R6: A slot covers the addresses a with base <= a < base+length, at byte granularity with no alignment. A slot of length 0 covers nothing.
- R7: The slot end is computed without wrap-around, so a slot whose base+length equals 2^64 covers the address 0xFFFF_FFFF_FFFF_FFFF and does not cover address 0.
- R8: `rsp_alloc` is 1 for type 1 and 0 for types 2, 4 and 5.
- R9: For type 3, `rsp_alloc` equals the value of `reclaim_done` in the request cycle.
- R10: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1.
- R11: A write takes effect at the clock edge that samples it. A lookup in the same cycle as a write sees the table as it was before that write.
- R12: Writing a slot replaces its previous contents. Writing it with `wr_valid` = 0 removes it from classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 4 | Slot index to write |
| wr_base | input | 64 | Window base byte address |
| wr_len | input | 64 | Window length in bytes |
| wr_code | input | 8 | Region type code |
| wr_valid | input | 1 | Slot valid bit to store |
| reclaim_done | input | 1 | Reclaimable regions may be allocated |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 64 | Address to classify |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_type | output | 3 | Effective region type |
| rsp_alloc | output | 1 | Address is allocatable |

## Verification
The bound checker watches several rules on every cycle. It checks the one-cycle request-to-response timing and the fallback to reserved when no slot hits. It also checks that the response never carries an out-of-range type, that reserved, non-volatile or defective results are never allocatable, and that a reclaimable result follows the reclaim-done level. Other behaviours only show up in the bench's scenarios against its reference model. These are the exact half-open window edges, odd byte bases, the top-of-space window, the restrictiveness ranking between particular overlapping types, unknown codes, and the old-contents view of a lookup made in the same cycle as a write.

// File: rtl/addr_class_pkg.sv
package addr_class_pkg;

  localparam int CODE_W = 8;
  localparam int RANK_W = 3;

  typedef enum logic [2:0] {
    RT_NONE = 3'd0,
    RT_RAM  = 3'd1,
    RT_RSVD = 3'd2,
    RT_RECL = 3'd3,
    RT_NVS  = 3'd4,
    RT_BAD  = 3'd5
  } region_t;

  // Severity rank: larger is more restrictive. Unknown codes rank as reserved.
  function automatic logic [RANK_W-1:0] code_rank(input logic [CODE_W-1:0] code);
    case (code)
      8'd1:    return 3'd0;
      8'd3:    return 3'd1;
      8'd4:    return 3'd2;
      8'd5:    return 3'd4;
      default: return 3'd3;
    endcase
  endfunction

  function automatic region_t rank_type(input logic [RANK_W-1:0] rank);
    case (rank)
      3'd0:    return RT_RAM;
      3'd1:    return RT_RECL;
      3'd2:    return RT_NVS;
      3'd4:    return RT_BAD;
      default: return RT_RSVD;
    endcase
  endfunction

endpackage

// File: rtl/region_slot.sv
module region_slot
  import addr_class_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [AW-1:0]       wr_base,
  input  logic [AW-1:0]       wr_len,
  input  logic [CODE_W-1:0]   wr_code,
  input  logic                wr_valid,
  input  logic [AW-1:0]       lk_addr,
  output logic                hit,
  output logic [RANK_W-1:0]   rank
);

  logic              vld_q;
  logic [AW-1:0]     base_q;
  logic [AW-1:0]     len_q;
  logic [RANK_W-1:0] rank_q;

  // Half-open window test with one extra bit so the end never wraps.
  function automatic logic in_window(input logic [AW-1:0] b,
                                     input logic [AW-1:0] l,
                                     input logic [AW-1:0] a);
    logic [AW:0] lim;
    lim = {1'b0, b} + {1'b0, l};
    return (a >= b) && ({1'b0, a} < lim);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else if (load) vld_q <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      base_q <= wr_base;
      len_q  <= wr_len;
      rank_q <= code_rank(wr_code);
    end
  end

  assign hit  = vld_q && in_window(base_q, len_q, lk_addr);
  assign rank = rank_q;

endmodule

// File: rtl/rank_reduce.sv
module rank_reduce
  import addr_class_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]              hit_vec,
  input  logic [N-1:0][RANK_W-1:0]  rank_vec,
  output logic                      any_hit,
  output logic [RANK_W-1:0]         top_rank
);

  always_comb begin
    any_hit  = 1'b0;
    top_rank = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        if (rank_vec[i] > top_rank) top_rank = rank_vec[i];
      end
    end
  end

endmodule

// File: rtl/addr_region_classifier.sv
module addr_region_classifier
  import addr_class_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int AW        = 64,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [AW-1:0]     wr_base,
  input  logic [AW-1:0]     wr_len,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_valid,
  input  logic              reclaim_done,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  output logic              rsp_valid,
  output logic [2:0]        rsp_type,
  output logic              rsp_alloc
);

  logic [N_ENTRIES-1:0]             hit_vec;
  logic [N_ENTRIES-1:0][RANK_W-1:0] rank_vec;
  logic                             any_hit;
  logic [RANK_W-1:0]                top_rank;
  region_t                          eff_type;
  logic                             alloc_now;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
    region_slot #(.AW(AW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_en && (wr_idx == IDX_W'(i))),
      .wr_base  (wr_base),
      .wr_len   (wr_len),
      .wr_code  (wr_code),
      .wr_valid (wr_valid),
      .lk_addr  (req_addr),
      .hit      (hit_vec[i]),
      .rank     (rank_vec[i])
    );
  end

  rank_reduce #(.N(N_ENTRIES)) u_reduce (
    .hit_vec  (hit_vec),
    .rank_vec (rank_vec),
    .any_hit  (any_hit),
    .top_rank (top_rank)
  );

  assign eff_type  = any_hit ? rank_type(top_rank) : RT_RSVD;
  assign alloc_now = (eff_type == RT_RAM) || ((eff_type == RT_RECL) && reclaim_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_type  <= RT_RSVD;
      rsp_alloc <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_type  <= eff_type;
        rsp_alloc <= alloc_now;
      end
    end
  end

endmodule

// File: rtl/addr_region_checker.sv
module addr_region_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       reclaim_done,
  input logic       any_hit,
  input logic [2:0] eff_type,
  input logic       rsp_valid,
  input logic [2:0] rsp_type,
  input logic       rsp_alloc
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R10

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R10

  AST_UNCOVERED_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !any_hit) |=> (rsp_type == 3'd2 && !rsp_alloc)); // R3

  AST_TYPE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_type >= 3'd1 && rsp_type <= 3'd5)); // R2

  AST_RESTRICTED_NOT_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_type == 3'd2 || rsp_type == 3'd4 || rsp_type == 3'd5)) |-> !rsp_alloc); // R8

  AST_RECLAIM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && eff_type == 3'd3) |=> (rsp_alloc == $past(reclaim_done))); // R9

endmodule

bind addr_region_classifier addr_region_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .reclaim_done (reclaim_done),
  .any_hit      (any_hit),
  .eff_type     (eff_type),
  .rsp_valid    (rsp_valid),
  .rsp_type     (rsp_type),
  .rsp_alloc    (rsp_alloc)
);

// File: tb/addr_region_classifier_bench.sv
`timescale 1ns/1ps
module addr_region_classifier_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [63:0] wr_base = '0;
  logic [63:0] wr_len = '0;
  logic [7:0]  wr_code = '0;
  logic        wr_valid = 1'b0;
  logic        reclaim_done = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_type;
  logic        rsp_alloc;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  addr_region_classifier u_addr_region_classifier (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_base(wr_base), .wr_len(wr_len), .wr_code(wr_code), .wr_valid(wr_valid),
    .reclaim_done(reclaim_done), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_alloc(rsp_alloc)
  );

  // ---------------- reference model ----------------
  logic [63:0] m_base [16];
  logic [63:0] m_len  [16];
  logic [7:0]  m_code [16];
  bit          m_vld  [16];
  bit          exp_valid = 0;
  int          exp_type  = 2;
  bit          exp_alloc = 0;

  // Position in the list of types ordered from least to most restrictive.
  function automatic int severity(input int t);
    int order [5] = '{1, 3, 4, 2, 5};
    for (int k = 0; k < 5; k++) if (order[k] == t) return k;
    return 3;
  endfunction

  function automatic int norm(input logic [7:0] c);
    return (c >= 8'd1 && c <= 8'd5) ? int'(c) : 2;
  endfunction

  function automatic int model_type(input logic [63:0] a);
    int best = -1;
    for (int j = 0; j < 16; j++) begin
      if (m_vld[j] && a >= m_base[j] && (a - m_base[j]) < m_len[j]) begin
        if (best < 0 || severity(norm(m_code[j])) > severity(best)) best = norm(m_code[j]);
      end
    end
    return (best < 0) ? 2 : best;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < 16; j++) m_vld[j] = 0;
      exp_valid <= 0;
    end else begin
      exp_valid <= req_valid;
      if (req_valid) begin
        exp_type  <= model_type(req_addr);
        exp_alloc <= (model_type(req_addr) == 1) || (model_type(req_addr) == 3 && reclaim_done);
      end
      if (wr_en) begin
        m_base[wr_idx] = wr_base;
        m_len[wr_idx]  = wr_len;
        m_code[wr_idx] = wr_code;
        m_vld[wr_idx]  = wr_valid;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // Per-cycle comparison against the model (R10 timing, R2/R5/R8/R9 values).
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 model rsp_valid", rsp_valid, exp_valid);
      if (exp_valid) begin
        chk("R5 model rsp_type", rsp_type, exp_type);
        chk("R8 model rsp_alloc", rsp_alloc, exp_alloc);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input bit w, input int idx, input logic [63:0] b, input logic [63:0] l,
                      input logic [7:0] c, input bit v, input bit r, input logic [63:0] a,
                      input bit rc);
    @(negedge clk);
    wr_en = w; wr_idx = idx[3:0]; wr_base = b; wr_len = l; wr_code = c; wr_valid = v;
    req_valid = r; req_addr = a; reclaim_done = rc;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
  endtask

  task automatic wr(input int idx, input logic [63:0] b, input logic [63:0] l,
                    input logic [7:0] c, input bit v);
    step(1, idx, b, l, c, v, 0, 64'd0, reclaim_done);
  endtask

  task automatic look(input logic [63:0] a, input bit rc, input int et, input bit ea,
                      input string tag);
    step(0, 0, 64'd0, 64'd0, 8'd0, 0, 1, a, rc);
    chk({tag, " valid"}, rsp_valid, 1);
    chk({tag, " type"}, rsp_type, et);
    chk({tag, " alloc"}, rsp_alloc, ea);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    look(64'h0, 0, 2, 0, "R1 empty table");
    look(64'hFFFF_FFFF_FFFF_FFFF, 1, 2, 0, "R1 empty table top");

    wr(0, 64'h0, 64'h9FC00, 8'd1, 1);
    look(64'h9FBFF, 0, 1, 1, "R2 R8 ram last byte");
    look(64'h9FC00, 0, 2, 0, "R6 R3 ram end exclusive");
    wr(1, 64'h9FC00, 64'h400, 8'd2, 1);
    look(64'h9FC00, 0, 2, 0, "R8 reserved");

    wr(2, 64'h100000, 64'h1000, 8'd3, 1);
    look(64'h100010, 0, 3, 0, "R9 reclaim not done");
    look(64'h100010, 1, 3, 1, "R9 reclaim done");
    wr(3, 64'h100800, 64'h10, 8'd4, 1);
    look(64'h100805, 1, 4, 0, "R5 nvs over reclaim");
    look(64'h100810, 1, 3, 1, "R6 R5 past nvs end");
    wr(4, 64'h100800, 64'h3, 8'd5, 1);
    look(64'h100801, 1, 5, 0, "R5 bad over nvs");
    wr(5, 64'h100000, 64'h1, 8'd9, 1);
    look(64'h100000, 1, 2, 0, "R4 unknown code over reclaim");
    wr(10, 64'h400000, 64'h8, 8'd0, 1);
    look(64'h400004, 1, 2, 0, "R4 code zero");

    wr(6, 64'h200000, 64'h0, 8'd1, 1);
    look(64'h200000, 1, 2, 0, "R6 zero length");
    wr(8, 64'h123, 64'h5, 8'd1, 1);
    look(64'h122, 1, 1, 1, "R6 inside ram below odd base");
    wr(0, 64'h0, 64'h100, 8'd1, 1);
    look(64'h122, 1, 2, 0, "R12 R6 below odd base");
    look(64'h123, 1, 1, 1, "R6 odd base");
    look(64'h127, 1, 1, 1, "R6 odd last byte");
    look(64'h128, 1, 2, 0, "R6 odd end");

    wr(7, 64'hFFFF_FFFF_FFFF_F000, 64'h1000, 8'd1, 1);
    look(64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 1, "R7 top byte");
    wr(0, 64'h0, 64'h9FC00, 8'd5, 0);
    look(64'h0, 1, 2, 0, "R7 R12 no wrap to zero");

    step(1, 9, 64'h300000, 64'h10, 8'd1, 1, 1, 64'h300000, 1);
    chk("R11 same-cycle old view", rsp_type, 2);
    look(64'h300000, 1, 1, 1, "R11 after write");
    wr(9, 64'h300000, 64'h10, 8'd1, 0);
    look(64'h300000, 1, 2, 0, "R12 invalidated");

    @(negedge clk);
    chk("R10 idle no response", rsp_valid, 0);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule